// File: doc/BRIEF.md
# Configurable Six-Input Logic Cell

This block is a single programmable function cell for a small soft logic array. Six routed data inputs feed a function that can be any Boolean function of those inputs. The function is held as four 16-entry truth tables. All four tables are addressed by the four low inputs. The two high inputs then pick one table output through a two-level multiplexer tree, which applies Shannon expansion once on each high input.

The function value goes either straight to the cell output (combinational mode) or through a D flip-flop (registered mode). The flip-flop is clocked by the array's shared clock and has no clock enable. An asynchronous init request forces the flip-flop to a configured value, which may be 0 or 1. An output-enable input sets the pin direction. When it is high, the cell drives its pin. When it is low, the pin is an input, and the level seen there is the external pad value. An unconnected pad reads as 1 because of its pull-up.

Configuration is one 66-bit word sent serially, most significant bit first, over a valid/ready bit stream. The sink never applies back-pressure: ready is always high, and a bit is taken on every clock edge where valid is high. The word collects in a shadow register. The whole word becomes active on the edge that accepts its last bit, so the cell never runs with a partly loaded configuration.

Top module: `cfg_logic_cell`

## Requirements
- R1: The configuration word is 66 bits. Bit 65 is the init value, bit 64 is the output mode (0 = combinational, 1 = registered), and bits 63..0 are the truth tables. The word is shifted in MSB first. It takes effect on the clock edge that accepts bit 0. Until that edge the previously active configuration remains in force.
- R2: While rst_n is low, all truth-table bits are 0, the mode is combinational and the init value is 0. As a result, cell_out is 0 for every input pattern.
- R3: In combinational mode, cell_out equals truth-table bit number p_in. Table t = {p_in[5], p_in[4]} occupies bits 16t+15..16t, and p_in[3:0] selects the bit within that table.
- R4: In registered mode, cell_out equals the function value sampled at the previous rising clk edge. The flip-flop loads on every edge while init_req is low.
- R5: When init_req rises, the flip-flop is set to the configured init value (0 or 1) at once, without waiting for a clock edge. It keeps that value across clock edges for as long as init_req stays high.
- R6: pin_drive follows oe. pin_level equals cell_out when oe is 1 and equals pad_in when oe is 0. An undriven pad is modelled as pad_in = 1.
- R7: cfg_ready is always 1. A configuration bit is consumed only on an edge where cfg_valid is 1. Gaps in cfg_valid neither drop nor insert bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared array clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration bit present |
| cfg_bit | input | 1 | Configuration bit, MSB of the word first |
| cfg_ready | output | 1 | Always 1; the cell never stalls the stream |
| p_in | input | 6 | Routed function inputs |
| init_req | input | 1 | Asynchronous flip-flop init request |
| oe | input | 1 | 1 = cell drives its pin |
| pad_in | input | 1 | External pad level (1 when undriven) |
| cell_out | output | 1 | Selected function or flip-flop value |
| pin_drive | output | 1 | Pin driver enable |
| pin_level | output | 1 | Resolved pin level |

## Verification
The bench builds the cell with its default parameters: 4 table address bits and 2 select bits, giving six inputs and a 66-bit configuration word. At this size one directed sweep can visit all 64 input patterns. Random tables and random input streams then exercise every table and both levels of the select tree in both output modes. The small word length also allows a partial load that stops one bit short, and a load with random gaps in cfg_valid, to be checked cheaply.

// File: rtl/cell_pkg.sv
package cell_pkg;
  localparam int DEF_ADDR_W = 4;
  localparam int DEF_SEL_W  = 2;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/cell_cfg_shift.sv
module cell_cfg_shift #(
  parameter int CFG_W = 66
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic [CFG_W-1:0] cfg_word,
  output logic [$clog2(CFG_W)-1:0] bit_count
);
  localparam int CNT_W = $clog2(CFG_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CFG_W - 1);

  logic [CFG_W-2:0] shadow;
  logic             last_bit;

  assign last_bit = (bit_count == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow    <= '0;
      bit_count <= '0;
      cfg_word  <= '0;
    end else if (bit_valid) begin
      if (last_bit) begin
        cfg_word  <= {shadow, bit_in};
        bit_count <= '0;
      end else begin
        shadow    <= {shadow[CFG_W-3:0], bit_in};
        bit_count <= bit_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cell_shannon_lut.sv
module cell_shannon_lut #(
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic [(1<<SEL_W)*(1<<ADDR_W)-1:0] tables,
  input  logic [ADDR_W+SEL_W-1:0]           idx,
  output logic                              f_out
);
  localparam int NUM_TBL = 1 << SEL_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NODES   = 2*NUM_TBL - 1;

  logic [ADDR_W-1:0] addr;
  logic [SEL_W-1:0]  sel;
  logic [NODES-1:0]  node;

  assign addr = idx[ADDR_W-1:0];
  assign sel  = idx[ADDR_W+SEL_W-1:ADDR_W];

  // leaves: one lookup per table, all sharing the low address
  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic [DEPTH-1:0] row;
    assign row                 = tables[t*DEPTH +: DEPTH];
    assign node[NUM_TBL-1+t]   = row[addr];
  end

  // mux tree: the root splits on the top select bit
  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    for (genvar j = 0; j < (1<<l); j++) begin : g_mux
      localparam int N = (1<<l) - 1 + j;
      assign node[N] = sel[SEL_W-1-l] ? node[2*N+2] : node[2*N+1];
    end
  end

  assign f_out = node[0];
endmodule

// File: rtl/cell_init_ff.sv
module cell_init_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req,
  input  logic init_val,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge init_req or negedge rst_n) begin
    if (!rst_n)        q <= 1'b0;
    else if (init_req) q <= init_val;
    else               q <= d;
  end
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import cell_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int SEL_W  = DEF_SEL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_valid,
  input  logic                    cfg_bit,
  output logic                    cfg_ready,
  input  logic [ADDR_W+SEL_W-1:0] p_in,
  input  logic                    init_req,
  input  logic                    oe,
  input  logic                    pad_in,
  output logic                    cell_out,
  output logic                    pin_drive,
  output logic                    pin_level
);
  localparam int TBL_BITS = (1 << SEL_W) * (1 << ADDR_W);
  localparam int CFG_W    = TBL_BITS + 2;
  localparam int CNT_W    = $clog2(CFG_W);

  logic [CFG_W-1:0] cfg_word;
  logic [CNT_W-1:0] load_cnt;
  logic             func_val;
  logic             flop_q;
  logic             init_val;
  out_mode_e        mode;

  assign cfg_ready = 1'b1;

  cell_cfg_shift #(.CFG_W(CFG_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (cfg_valid),
    .bit_in    (cfg_bit),
    .cfg_word  (cfg_word),
    .bit_count (load_cnt)
  );

  assign init_val = cfg_word[CFG_W-1];
  assign mode     = out_mode_e'(cfg_word[CFG_W-2]);

  cell_shannon_lut #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_lut (
    .tables (cfg_word[TBL_BITS-1:0]),
    .idx    (p_in),
    .f_out  (func_val)
  );

  cell_init_ff u_ff (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .init_val (init_val),
    .d        (func_val),
    .q        (flop_q)
  );

  assign cell_out  = (mode == OUT_REG) ? flop_q : func_val;
  assign pin_drive = oe;
  assign pin_level = oe ? cell_out : pad_in;
endmodule

// File: rtl/cfg_logic_cell_chk.sv
module cfg_logic_cell_chk #(
  parameter int CFG_W = 66,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             init_req,
  input logic             oe,
  input logic             pad_in,
  input logic             cell_out,
  input logic             pin_level,
  input logic             cfg_ready,
  input logic             func_val,
  input logic             flop_q,
  input logic             init_val,
  input logic [CFG_W-1:0] cfg_word,
  input logic [CNT_W-1:0] load_cnt
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CFG_W - 1);

  // R1: the active word changes only on the edge taking the final bit
  a_r1_commit_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && load_cnt == LAST_IDX) |=> $stable(cfg_word));

  // R1: bit counter never runs past the word length
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    load_cnt <= LAST_IDX);

  // R4: the flip-flop holds the function value of the previous edge
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !init_req ##1 !init_req |-> flop_q == $past(func_val));

  // R5: during init the flip-flop shows the configured init value
  a_r5_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
    init_req && $stable(init_val) |-> flop_q == init_val);

  // R6: with the driver off the pin follows the pad
  a_r6_pin_input: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> pin_level == pad_in);

  // R6: with the driver on the pin follows the cell
  a_r6_pin_output: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> pin_level == cell_out);

  // R7: no back-pressure
  a_r7_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> cfg_ready);
endmodule

bind cfg_logic_cell cfg_logic_cell_chk #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .init_req  (init_req),
  .oe        (oe),
  .pad_in    (pad_in),
  .cell_out  (cell_out),
  .pin_level (pin_level),
  .cfg_ready (cfg_ready),
  .func_val  (func_val),
  .flop_q    (flop_q),
  .init_val  (init_val),
  .cfg_word  (cfg_word),
  .load_cnt  (load_cnt)
);

// File: tb/cfg_logic_cell_tb.sv
`timescale 1ns/100ps
module cfg_logic_cell_tb;
  localparam int CFG_W = 66;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_bit = 1'b0;
  logic       cfg_ready;
  logic [5:0] p_in = '0;
  logic       init_req = 1'b0;
  logic       oe = 1'b1;
  logic       pad_in = 1'b1;
  logic       cell_out;
  logic       pin_drive;
  logic       pin_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cfg_logic_cell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_bit(cfg_bit),
    .cfg_ready(cfg_ready), .p_in(p_in), .init_req(init_req), .oe(oe),
    .pad_in(pad_in), .cell_out(cell_out), .pin_drive(pin_drive),
    .pin_level(pin_level)
  );

  function automatic logic model_f(logic [63:0] tbl, logic [5:0] p);
    return tbl[p];
  endfunction

  function automatic logic [CFG_W-1:0] mk_word(logic ival, logic regm, logic [63:0] tbl);
    return {ival, regm, tbl};
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send_bits(logic [CFG_W-1:0] w, int hi, int lo, bit gaps);
    for (int i = hi; i >= lo; i--) begin
      if (gaps) begin
        int idle = $urandom_range(0, 2);
        for (int g = 0; g < idle; g++) begin
          @(negedge clk);
          cfg_valid = 1'b0;
          cfg_bit   = ~w[i];
        end
      end
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_bit   = w[i];
      #0.5 check("R7 ready", cfg_ready, 1'b1);
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic load(logic [CFG_W-1:0] w, bit gaps);
    send_bits(w, CFG_W-1, 0, gaps);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] tbl;
    logic [5:0]  prev;
    void'($urandom(32'h5EED_0042));

    // R2: reset state
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      p_in = 6'($urandom);
      #0.5 check("R2 reset output", cell_out, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    p_in = 6'h3F;
    #0.5 check("R2 after release", cell_out, 1'b0);

    // R6: pin direction and pull-up
    @(negedge clk);
    oe = 1'b0; pad_in = 1'b1;
    #0.5 check("R6 undriven pad", pin_level, 1'b1);
    check("R6 drive off", pin_drive, 1'b0);
    pad_in = 1'b0;
    #0.5 check("R6 pad low", pin_level, 1'b0);
    oe = 1'b1; pad_in = 1'b1;
    #0.5 check("R6 drive on", pin_drive, 1'b1);
    check("R6 drives cell", pin_level, cell_out);

    // R1: partial load leaves old config active
    tbl = '1;
    send_bits(mk_word(1'b0, 1'b0, tbl), CFG_W-1, 1, 1'b0);
    p_in = 6'd9;
    #0.5 check("R1 partial load", cell_out, 1'b0);
    send_bits(mk_word(1'b0, 1'b0, tbl), 0, 0, 1'b0);
    #0.5 check("R1 commit", cell_out, 1'b1);

    // R3: exhaustive sweep with a directed pattern (one-hot per table)
    tbl = 64'h8000_0100_0010_0001;
    load(mk_word(1'b0, 1'b0, tbl), 1'b0);
    for (int p = 0; p < 64; p++) begin
      p_in = 6'(p);
      #0.5 check("R3 sweep", cell_out, model_f(tbl, 6'(p)));
    end

    // R3: random tables, combinational
    for (int c = 0; c < 8; c++) begin
      tbl = {$urandom, $urandom};
      load(mk_word(1'($urandom), 1'b0, tbl), 1'b0);
      for (int k = 0; k < 24; k++) begin
        p_in = 6'($urandom);
        #0.5 check("R3 random", cell_out, model_f(tbl, p_in));
        oe = 1'($urandom); pad_in = 1'($urandom);
        #0.5 check("R6 random", pin_level, oe ? model_f(tbl, p_in) : pad_in);
        oe = 1'b1;
      end
    end

    // R7: load with gaps in valid, then verify function
    tbl = {$urandom, $urandom};
    load(mk_word(1'b0, 1'b0, tbl), 1'b1);
    for (int k = 0; k < 16; k++) begin
      p_in = 6'($urandom);
      #0.5 check("R7 gapped load", cell_out, model_f(tbl, p_in));
    end

    // R4: registered mode
    for (int c = 0; c < 6; c++) begin
      tbl = {$urandom, $urandom};
      load(mk_word(1'b0, 1'b1, tbl), 1'b0);
      prev = 6'($urandom);
      p_in = prev;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        #0.5 check("R4 registered", cell_out, model_f(tbl, prev));
        prev = 6'($urandom);
        p_in = prev;
      end
    end

    // R5: async init to 1 then to 0
    for (int v = 1; v >= 0; v--) begin
      tbl = (v == 1) ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF;
      load(mk_word(1'(v), 1'b1, tbl), 1'b0);
      p_in = 6'd17;
      @(negedge clk);
      #0.5 check("R5 pre-init", cell_out, model_f(tbl, p_in));
      #0.5 init_req = 1'b1;
      #0.5 check("R5 async set", cell_out, 1'(v));
      repeat (3) begin
        @(negedge clk);
        #0.5 check("R5 hold", cell_out, 1'(v));
      end
      init_req = 1'b0;
      @(negedge clk);
      #0.5 check("R5 release", cell_out, model_f(tbl, p_in));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule